// File: doc/BRIEF.md
# Fractional baud tick generator

This block derives the 16x oversampling tick for a UART transmitter and receiver from a fast system clock. One bit time is split into sixteen slots. Each slot lasts the programmed integer divisor plus one clock. It lasts one clock more when the slot's bit in a 16-bit stretch mask is set. The fraction of the divide ratio is therefore the number of set mask bits over sixteen. The extra clocks are spread across the bit time in the pattern the mask gives, instead of being bunched at its end.

Software programs the divisor so that divisor + ones/16 = f_clk / (16 × baud) − 1. For example, a 40 MHz clock at 115200 baud needs a divisor of 20 and eleven stretched slots. The mask can be supplied directly. It can also be built inside the block from a 4-bit count of stretched slots, using a fixed table of evenly spread patterns. The block emits a one-clock tick at the end of every slot and a bit strobe that coincides with the tick closing the last slot of a bit.

Top module: `frac_baud_gen`

## Requirements
- R1: While enabled, a slot whose mask bit is 0 lasts divisor + 1 clocks and a slot whose mask bit is 1 lasts divisor + 2 clocks. Slot length is measured as the spacing between ticks. The first slot is measured from the first clock edge at which enable is sampled high.
- R2: The slot index starts at 0 (mask bit 0) when enable rises, advances by one per tick, and wraps from 15 back to 0.
- R3: `bit_strobe` is high only together with the tick that ends slot 15, once per sixteen ticks.
- R4: `tick` is high for exactly one clock per slot, for any divisor of 1 or more.
- R5: Over each complete bit time the total is exactly 16 × (divisor + 1) + (number of ones in the mask) clocks.
- R6: With `mask_from_count` high, the mask in use is taken from `extra_count`: 0→0x0000, 1→0x0080, 2→0x0808, 3→0x0888, 4→0x2222, 5→0x4924, 6→0x4A52, 7→0x54AA, 8→0x5555, 9→0xD555, 10→0xD5D5, 11→0xDDD5, 12→0xDDDD, 13→0xDFDD, 14→0xDFDF, 15→0xFFDF. With it low, `slot_mask` is used as given.
- R7: A change of divisor or mask while enabled leaves the slot in progress untouched and applies from the next slot onward.
- R8: While `en` is low no tick or strobe is produced, and the slot counter and index return to zero, so the next enable starts a fresh slot 0.
- R9: While `rst` is high, `tick` and `bit_strobe` stay low even when `en` is high.
- R10: The full 16-bit divisor range is supported: divisor 65535 with a clear mask bit gives a 65536-clock slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the slot counter and index |
| divisor | input | 16 | Integer part of the divide ratio (1 to 65535) |
| slot_mask | input | 16 | Per-slot stretch mask, bit n for slot n |
| mask_from_count | input | 1 | Select the internally built mask |
| extra_count | input | 4 | Number of stretched slots for the built mask |
| tick | output | 1 | One-clock oversample tick at each slot end |
| bit_strobe | output | 1 | One-clock strobe with the tick ending slot 15 |

## Verification
A corrupted slot counter shows at the ports within one slot, as a tick that arrives early or late against the divisor and the current mask bit. A wrong slot index, or a wrong pick of mask bit, shows within one bit time. It appears as a stretched slot in the wrong place, or as a bit strobe on a tick other than the sixteenth. Because every slot spacing is compared with divisor + 1 + mask bit, any slip is caught in the slot where it happens. A wrongly built count pattern shows within a single bit, as a misplaced stretch and a per-bit total that does not match.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int unsigned DIV_W  = 16;
    localparam int unsigned SLOT_N = 16;
    localparam int unsigned IDX_W  = $clog2(SLOT_N);
    localparam int unsigned CNT_W  = DIV_W + 1;
    localparam int unsigned XCNT_W = $clog2(SLOT_N);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SLOT_N-1:0] mask;
    } slot_cfg_t;

    // Evenly spread stretch pattern for a given number of long slots.
    function automatic logic [SLOT_N-1:0] spread_pattern(input logic [XCNT_W-1:0] n);
        logic [SLOT_N-1:0] p;
        case (n)
            4'd0:    p = 16'h0000;
            4'd1:    p = 16'h0080;
            4'd2:    p = 16'h0808;
            4'd3:    p = 16'h0888;
            4'd4:    p = 16'h2222;
            4'd5:    p = 16'h4924;
            4'd6:    p = 16'h4A52;
            4'd7:    p = 16'h54AA;
            4'd8:    p = 16'h5555;
            4'd9:    p = 16'hD555;
            4'd10:   p = 16'hD5D5;
            4'd11:   p = 16'hDDD5;
            4'd12:   p = 16'hDDDD;
            4'd13:   p = 16'hDFDD;
            4'd14:   p = 16'hDFDF;
            default: p = 16'hFFDF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/baud_mask_src.sv
module baud_mask_src
    import fbg_pkg::*;
#(
    parameter bit HAS_COUNT_PATH = 1'b1
) (
    input  logic [SLOT_N-1:0] raw_mask,
    input  logic              use_count,
    input  logic [XCNT_W-1:0] long_count,
    output logic [SLOT_N-1:0] mask
);

    generate
        if (HAS_COUNT_PATH) begin : g_count
            // R6: pattern built from the count of stretched slots
            always_comb begin
                if (use_count) mask = spread_pattern(long_count);
                else           mask = raw_mask;
            end
        end else begin : g_direct
            logic unused_sel;
            assign unused_sel = ^{use_count, long_count};
            assign mask = raw_mask;
        end
    endgenerate

endmodule

// File: rtl/baud_slot_timer.sv
module baud_slot_timer
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  slot_cfg_t        cfg_in,
    input  logic [IDX_W-1:0] idx,
    output logic             boundary,
    output slot_cfg_t        cfg_q
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Slot spans limit+1 clocks: divisor+1, plus one when the slot is stretched.
    assign limit    = {1'b0, cfg_q.div} + CNT_W'(cfg_q.mask[idx]);
    assign boundary = en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            cfg_q <= cfg_in;
        end else if (boundary) begin
            cnt   <= '0;
            cfg_q <= cfg_in;   // new settings take hold for the next slot only
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/baud_slot_seq.sv
module baud_slot_seq
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             boundary,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    assign last = (idx == IDX_W'(SLOT_N - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)    idx <= '0;
        else if (boundary) idx <= idx + 1'b1;   // wraps after the final slot
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter bit HAS_COUNT_PATH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [SLOT_N-1:0] slot_mask,
    input  logic              mask_from_count,
    input  logic [XCNT_W-1:0] extra_count,
    output logic              tick,
    output logic              bit_strobe
);

    slot_cfg_t        next_cfg;
    slot_cfg_t        cur_cfg;
    logic [SLOT_N-1:0] sel_mask;
    logic             boundary;
    logic [IDX_W-1:0] slot_idx;
    logic             slot_last;
    logic [DIV_W-1:0] cur_div;

    baud_mask_src #(.HAS_COUNT_PATH(HAS_COUNT_PATH)) u_mask (
        .raw_mask   (slot_mask),
        .use_count  (mask_from_count),
        .long_count (extra_count),
        .mask       (sel_mask)
    );

    assign next_cfg.div  = divisor;
    assign next_cfg.mask = sel_mask;
    assign cur_div       = cur_cfg.div;

    baud_slot_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_in   (next_cfg),
        .idx      (slot_idx),
        .boundary (boundary),
        .cfg_q    (cur_cfg)
    );

    baud_slot_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .boundary (boundary),
        .idx      (slot_idx),
        .last     (slot_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tick       <= 1'b0;
            bit_strobe <= 1'b0;
        end else begin
            tick       <= boundary;
            bit_strobe <= boundary && slot_last;
        end
    end

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk
    import fbg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             tick,
    input logic             bit_strobe,
    input logic             boundary,
    input logic [IDX_W-1:0] idx,
    input logic [DIV_W-1:0] cur_div
);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R3
    strobe_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> tick);

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cur_div != '0) |=> !tick);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tick && !bit_strobe));

    // R2
    index_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && idx == IDX_W'(SLOT_N - 1)) |=> (idx == '0));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !boundary) |=> $stable(cur_div));

    // R9
    always_ff @(posedge clk) begin
        if (rst_d) begin
            reset_quiet_chk: assert (!tick && !bit_strobe);
        end
    end

endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .bit_strobe (bit_strobe),
    .boundary   (boundary),
    .idx        (slot_idx),
    .cur_div    (cur_div)
);

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [15:0] slot_mask = 16'h0000;
    logic        mask_from_count = 1'b0;
    logic [3:0]  extra_count = 4'd0;
    logic        tick;
    logic        bit_strobe;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    frac_baud_gen u0 (
        .clk             (clk),
        .rst             (rst),
        .en              (en),
        .divisor         (divisor),
        .slot_mask       (slot_mask),
        .mask_from_count (mask_from_count),
        .extra_count     (extra_count),
        .tick            (tick),
        .bit_strobe      (bit_strobe)
    );

    typedef struct packed {
        logic [15:0] div;
        logic [15:0] mask;
        logic        sel;
        logic [3:0]  cnt;
        logic [7:0]  slots;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{16'd20, 16'hDDD5, 1'b0, 4'd0,  8'd32},
        '{16'd1,  16'h0000, 1'b0, 4'd0,  8'd32},
        '{16'd3,  16'hFFFF, 1'b0, 4'd0,  8'd32},
        '{16'd5,  16'h0001, 1'b0, 4'd0,  8'd16},
        '{16'd1,  16'hA5C3, 1'b0, 4'd0,  8'd48},
        '{16'd2,  16'h1234, 1'b1, 4'd11, 8'd16},
        '{16'd4,  16'hFFFF, 1'b1, 4'd0,  8'd16},
        '{16'd1,  16'h0000, 1'b1, 4'd15, 8'd16},
        '{16'd7,  16'h0000, 1'b1, 4'd5,  8'd16}
    };

    function automatic logic [15:0] expect_pattern(input logic [3:0] n);
        logic [15:0] t [16] = '{16'h0000, 16'h0080, 16'h0808, 16'h0888,
                               16'h2222, 16'h4924, 16'h4A52, 16'h54AA,
                               16'h5555, 16'hD555, 16'hD5D5, 16'hDDD5,
                               16'hDDDD, 16'hDFDD, 16'hDFDF, 16'hFFDF};
        return t[n];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges until the next tick; returns the spacing.
    task automatic wait_tick(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!tick && len < 70000);
    endtask

    task automatic run_case(input int dv, input logic [15:0] m, input logic sel,
                            input logic [3:0] c, input int nslots, input string tag);
        logic [15:0] em;
        int sum;
        int len;
        em = sel ? expect_pattern(c) : m;
        en = 1'b0;
        divisor = 16'(dv);
        slot_mask = m;
        mask_from_count = sel;
        extra_count = c;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        sum = 0;
        for (int s = 0; s < nslots; s++) begin
            wait_tick(len);
            // R1 / R6: spacing follows divisor and the mask bit of this slot
            check(len == dv + 1 + int'(em[s % 16]), tag, len, dv + 1 + int'(em[s % 16]));
            // R2 / R3: strobe only on the sixteenth tick
            check(bit_strobe == (s % 16 == 15), "R3", int'(bit_strobe), int'(s % 16 == 15));
            sum += len;
            if (s % 16 == 15) begin
                // R5: per-bit total
                check(sum == 16 * (dv + 1) + $countones(em), "R5", sum, 16 * (dv + 1) + $countones(em));
                sum = 0;
            end
        end
        en = 1'b0;
    endtask

    initial begin
        int len;
        int seen;
        // R9: reset holds outputs low even with enable high
        en = 1'b1;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tick || bit_strobe) seen++;
        end
        check(seen == 0, "R9", seen, 0);
        rst = 1'b0;
        en = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_case(int'(VECS[v].div), VECS[v].mask, VECS[v].sel, VECS[v].cnt,
                     int'(VECS[v].slots), VECS[v].sel ? "R6" : "R1");
        end

        // R6: every count value over one bit
        for (int c = 0; c < 16; c++) begin
            run_case(1, 16'h0000, 1'b1, 4'(c), 16, "R6");
        end

        // R4: tick lasts one clock
        divisor = 16'd2;
        slot_mask = 16'h0000;
        mask_from_count = 1'b0;
        @(negedge clk);
        en = 1'b1;
        wait_tick(len);
        @(negedge clk);
        check(tick == 1'b0, "R4", int'(tick), 0);

        // R7: change mid-slot takes effect one slot later
        en = 1'b0;
        divisor = 16'd4;
        @(negedge clk);
        en = 1'b1;
        wait_tick(len);
        check(len == 5, "R7", len, 5);
        @(negedge clk);
        @(negedge clk);
        divisor = 16'd7;
        slot_mask = 16'h0004;
        begin
            int l1;
            int l2;
            wait_tick(l1);
            l1 += 2;
            check(l1 == 5, "R7", l1, 5);
            wait_tick(l2);
            check(l2 == 9, "R7", l2, 9);
        end

        // R8: disable mid-slot, no ticks while low, fresh slot 0 afterwards
        repeat (13) @(negedge clk);
        en = 1'b0;
        seen = 0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (tick || bit_strobe) seen++;
        end
        check(seen == 0, "R8", seen, 0);
        run_case(3, 16'h8001, 1'b0, 4'd0, 16, "R8");

        // R10: largest divisor
        run_case(65535, 16'h0000, 1'b0, 4'd0, 1, "R10");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule